// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a register-mapped countdown timer of the kind that sits beside a processor's local interrupt controller. Software reaches it through a plain register port with a 12-bit byte offset, 32-bit write and read data, and separate write and read strobes. Four locations sit behind the port. The vector-table word holds an 8-bit interrupt vector, a mask bit and a two-bit mode field. A start-count register loads the countdown. A read-only live-count register shows the countdown as it runs. A divide register selects how many bus clocks make up one countdown step.

A prescaler turns the bus clock into steps. Each step lowers the live count by one. When the count reaches zero, the block emits a one-clock interrupt pulse that carries the programmed vector, unless the mask bit is set. In one-shot mode the count then stays at zero. In periodic mode the count reloads from the start count on the next step and runs again. A mode value that selects the external-deadline time base parks the countdown at zero. Writing the start count restarts the countdown, and writing zero to it stops the countdown. Software that wants the final count must therefore read it before the stopping write.

Top module: `lcl_irq_timer`

## Requirements
- R1: The divide register decodes bits {3,1,0} as one 3-bit code c, and bit 2 has no effect. The step length is 2^((c+1) mod 8) bus clocks, so value 0x0 gives 2, 0x1 gives 4, 0x2 gives 8, 0x3 gives 16, 0x8 gives 32, 0x9 gives 64, 0xA gives 128 and 0xB gives 1.
- R2: A write to the start count (offset 0x380) or to the divide register (offset 0x3E0) restarts the prescaler. If that write is sampled at edge E, the next decrement happens at edge E + ratio and every ratio edges after that.
- R3: A nonzero write to the start count copies the value into the live count (offset 0x390). After k steps, a read of the live count returns the start value minus k.
- R4: Bit 16 of the vector-table word (offset 0x320) is the mask. While it is set, reaching zero raises no interrupt, but counting continues unchanged.
- R5: In one-shot mode (bits 18:17 = 0), reaching zero raises irqPulse for exactly one clock, with irqVector equal to bits 7:0 of the vector-table word. The count then stays at zero with no further pulse.
- R6: In periodic mode (bits 18:17 = 1), the step after reaching zero reloads the start count. Each arrival at zero raises a new pulse, so the pulse period is start count + 1 steps.
- R7: Writing zero to the start count stops the countdown. The live count then reads zero and stays at zero, and no pulse follows.
- R8: With bits 18:17 = 2 or 3 (external-deadline time base), the live count is held at zero and no pulse is raised, even after a start-count write.
- R9: Writes to the live-count offset are ignored. Reads of any offset other than 0x320, 0x380, 0x390 and 0x3E0 return zero.
- R10: A read strobe sampled at edge E places the addressed value on regRdData after E, and regRdData holds it until the next read. The vector-table word reads back bits 18:16 and 7:0 as written, with other bits zero. The start count reads back as written. The divide register reads back its 4 bits. After reset the vector-table word reads 0x00010000 (masked) and every other register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regWr | input | 1 | Write strobe, one clock per write |
| regRd | input | 1 | Read strobe, one clock per read |
| regRdData | output | 32 | Registered read data |
| irqPulse | output | 1 | One-clock interrupt request |
| irqVector | output | 8 | Vector that goes with irqPulse |

## Verification
The bench walks every divide code, including two codes with bit 2 set. It reads the live count one clock before and one clock after the first step is due. An off-by-one prescaler, or a decode that honours bit 2, then shows up as a count that is one too high or one too low. A second divide write in the middle of a step checks that the prescaler restarts. A design that kept the old phase would show a decrement one read too early. The periodic run counts pulses over a fixed window: a reload at the zero edge instead of one step later changes the count, and a pulse held for two clocks doubles it. Masking, the deadline mode and writes to the live count are each judged by reading the count back and tallying pulses, so a design that stops counting when masked, or that takes the written value, is caught at the ports.

// File: rtl/lcl_irq_timer_pkg.sv
package lcl_irq_timer_pkg;

  localparam int unsigned REG_ADDR_W = 12;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned SHIFT_W    = 3;
  localparam int unsigned DIV_W      = 4;

  // Register byte offsets; software depends on these
  localparam logic [REG_ADDR_W-1:0] OFS_VT   = 12'h320;
  localparam logic [REG_ADDR_W-1:0] OFS_INIT = 12'h380;
  localparam logic [REG_ADDR_W-1:0] OFS_CUR  = 12'h390;
  localparam logic [REG_ADDR_W-1:0] OFS_DIV  = 12'h3E0;

  // Field positions inside the vector-table word
  localparam int unsigned VT_MASK_BIT = 16;
  localparam int unsigned VT_MODE_LO  = 17;
  localparam int unsigned VT_MODE_HI  = 18;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic               masked;
    tmrMode_e           mode;
    logic [SHIFT_W-1:0] divShift;
  } tmrCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadInit;
    logic clrPre;
  } tmrStrobe_t;

  // Bits {3,1,0} form a code; the ratio is 2^((code+1) mod 8), so the
  // top code wraps to a shift of 0 (divide by one).
  function automatic logic [SHIFT_W-1:0] divCodeToShift(input logic [DIV_W-1:0] code);
    logic [SHIFT_W-1:0] packedCode;
    packedCode = {code[3], code[1], code[0]};
    return packedCode + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/lcl_irq_timer_ctrl.sv
module lcl_irq_timer_ctrl
  import lcl_irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  regWr,
  input  logic                  regRd,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [DATA_W-1:0]     curCnt,
  output logic [DATA_W-1:0]     initCnt,
  output tmrCfg_t               cfg,
  output tmrStrobe_t            strb
);

  logic [VEC_W-1:0] vecReg;
  logic             maskReg;
  tmrMode_e         modeReg;
  logic [DIV_W-1:0] divReg;

  logic hitVt, hitInit, hitCur, hitDiv, hitAny;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] vtWord;

  assign hitVt   = (regAddr == OFS_VT);
  assign hitInit = (regAddr == OFS_INIT);
  assign hitCur  = (regAddr == OFS_CUR);
  assign hitDiv  = (regAddr == OFS_DIV);
  assign hitAny  = hitVt | hitInit | hitCur | hitDiv;

  // Register writes; the live-count offset has no write path at all
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg  <= '0;
      maskReg <= 1'b1;
      modeReg <= MODE_ONESHOT;
      divReg  <= '0;
      initCnt <= '0;
    end else if (regWr) begin
      if (hitVt) begin
        vecReg  <= regWrData[VEC_W-1:0];
        maskReg <= regWrData[VT_MASK_BIT];
        modeReg <= tmrMode_e'(regWrData[VT_MODE_HI:VT_MODE_LO]);
      end
      if (hitDiv)  divReg  <= regWrData[DIV_W-1:0];
      if (hitInit) initCnt <= regWrData;
    end
  end

  assign strb.loadInit = regWr & hitInit;
  assign strb.clrPre   = regWr & (hitInit | hitDiv);

  assign cfg.vector   = vecReg;
  assign cfg.masked   = maskReg;
  assign cfg.mode     = modeReg;
  assign cfg.divShift = divCodeToShift(divReg);

  always_comb begin
    vtWord = '0;
    vtWord[VEC_W-1:0]               = vecReg;
    vtWord[VT_MASK_BIT]             = maskReg;
    vtWord[VT_MODE_HI:VT_MODE_LO]   = modeReg;
  end

  always_comb begin
    rdMux = '0;
    if (hitVt)   rdMux = vtWord;
    if (hitInit) rdMux = initCnt;
    if (hitCur)  rdMux = curCnt;
    if (hitDiv)  rdMux = DATA_W'(divReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdData <= '0;
    else if (regRd) regRdData <= rdMux;
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !hitAny) |=> (regRdData == '0)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!regRd && $past(rstN)) |=> $stable(regRdData)); // R10

endmodule

// File: rtl/lcl_irq_timer_dp.sv
module lcl_irq_timer_dp
  import lcl_irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrCfg_t           cfg,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] initCnt,
  output logic [DATA_W-1:0] curCnt,
  output logic              irqPulse,
  output logic [VEC_W-1:0]  irqVector
);

  localparam int unsigned PRE_W = MAX_SHIFT;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] ratioM1;
  logic             running;
  logic             tick;
  logic             deadline;
  logic             periodic;
  logic             hitOne;

  // 2^shift - 1; the top shift wraps to all ones in PRE_W bits
  assign ratioM1  = (PRE_W'(1) << cfg.divShift) - PRE_W'(1);
  assign tick     = running && (preCnt == ratioM1);
  assign deadline = cfg.mode[1];
  assign periodic = (cfg.mode == MODE_PERIODIC);
  assign hitOne   = (curCnt == DATA_W'(1));

  // Prescaler
  always_ff @(posedge clk) begin
    if (!rstN)             preCnt <= '0;
    else if (strb.clrPre)  preCnt <= '0;
    else if (!running)     preCnt <= '0;
    else if (tick)         preCnt <= '0;
    else                   preCnt <= preCnt + PRE_W'(1);
  end

  // Countdown and expiry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCnt    <= '0;
      running   <= 1'b0;
      irqPulse  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqPulse <= 1'b0;
      if (deadline) begin
        curCnt  <= '0;
        running <= 1'b0;
      end else if (strb.loadInit) begin
        curCnt  <= loadVal;
        running <= (loadVal != '0);
      end else if (tick) begin
        if (curCnt == '0) begin
          if (periodic) curCnt  <= initCnt;
          else          running <= 1'b0;
        end else begin
          curCnt <= curCnt - DATA_W'(1);
          if (hitOne) begin
            if (!cfg.masked) begin
              irqPulse  <= 1'b1;
              irqVector <= cfg.vector;
            end
            if (!periodic) running <= 1'b0;
          end
        end
      end
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= ratioM1); // R2

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.loadInit && !deadline && curCnt > DATA_W'(1))
      |=> (curCnt == $past(curCnt) - DATA_W'(1))); // R3

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !$past(cfg.masked)); // R4

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R5

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_ONESHOT && curCnt == '0 && !strb.loadInit)
      |=> (curCnt == '0)); // R5

  AST_DEADLINE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(deadline) && $past(rstN)) |-> (curCnt == '0 && !irqPulse)); // R8

endmodule

// File: rtl/lcl_irq_timer.sv
module lcl_irq_timer
  import lcl_irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  regWr,
  input  logic                  regRd,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  irqPulse,
  output logic [VEC_W-1:0]      irqVector
);

  localparam int unsigned MAX_SHIFT = (1 << SHIFT_W) - 1;

  tmrCfg_t           cfg;
  tmrStrobe_t        strb;
  logic [DATA_W-1:0] curCnt;
  logic [DATA_W-1:0] initCnt;

  lcl_irq_timer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWr     (regWr),
    .regRd     (regRd),
    .regRdData (regRdData),
    .curCnt    (curCnt),
    .initCnt   (initCnt),
    .cfg       (cfg),
    .strb      (strb)
  );

  lcl_irq_timer_dp #(.DATA_W(DATA_W), .MAX_SHIFT(MAX_SHIFT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .strb      (strb),
    .loadVal   (regWrData),
    .initCnt   (initCnt),
    .curCnt    (curCnt),
    .irqPulse  (irqPulse),
    .irqVector (irqVector)
  );

endmodule

// File: tb/lcl_irq_timer_bench.sv
module lcl_irq_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regRdData;
  logic        irqPulse;
  logic [7:0]  irqVector;

  int checks = 0;
  int fails = 0;
  int irqCount = 0;
  logic [7:0] lastVec = '0;
  bit done = 1'b0;

  localparam logic [11:0] A_VT = 12'h320, A_INIT = 12'h380,
                          A_CUR = 12'h390, A_DIV = 12'h3E0;

  always #2 clk = ~clk;   // 250 MHz

  lcl_irq_timer u_lcl_irq_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(regRdData),
    .irqPulse(irqPulse), .irqVector(irqVector)
  );

  always @(negedge clk) begin
    if (rstN && irqPulse) begin
      irqCount++;
      lastVec = irqVector;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; regRd = 1'b1;
    @(posedge clk); @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ratioOf(input logic [3:0] code);
    case ({code[3], code[1], code[0]})
      3'b000: return 2;   3'b001: return 4;
      3'b010: return 8;   3'b011: return 16;
      3'b100: return 32;  3'b101: return 64;
      3'b110: return 128; default: return 1;
    endcase
  endfunction

  task automatic testReset();
    logic [31:0] v;
    chk("R10 irq idle after reset", {31'b0, irqPulse}, 32'h0);
    rdReg(A_VT, v);   chk("R10 reset vector-table", v, 32'h0001_0000);
    rdReg(A_DIV, v);  chk("R10 reset divide", v, 32'h0);
    rdReg(A_CUR, v);  chk("R10 reset live count", v, 32'h0);
    rdReg(A_INIT, v); chk("R10 reset start count", v, 32'h0);
  endtask

  task automatic testReadback();
    logic [31:0] v;
    wrReg(A_VT, 32'hFFFF_FFAB);
    rdReg(A_VT, v);  chk("R10 vector-table readback", v, 32'h0007_00AB);
    wrReg(A_DIV, 32'h0000_000A);
    rdReg(A_DIV, v); chk("R10 divide readback", v, 32'h0000_000A);
    wrReg(A_VT, 32'h0001_0000);
    rdReg(12'h300, v); chk("R9 unmapped read is zero", v, 32'h0);
  endtask

  task automatic testDivide();
    logic [3:0] codes [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'h4, 4'hF};
    logic [31:0] v;
    for (int i = 0; i < 10; i++) begin
      int r;
      r = ratioOf(codes[i]);
      wrReg(A_DIV, {28'b0, codes[i]});
      wrReg(A_INIT, 32'd1000);
      waitCyc(4 * r - 1);
      rdReg(A_CUR, v);
      chk($sformatf("R1 divide code 0x%0h", codes[i]), v, 32'd997);
      wrReg(A_INIT, 32'd0);
    end
  endtask

  task automatic testFirstStep();
    logic [31:0] v;
    wrReg(A_DIV, 32'h2);   // divide by 8
    wrReg(A_INIT, 32'd1000);
    waitCyc(7);
    rdReg(A_CUR, v); chk("R2 no step before one period", v, 32'd1000);
    rdReg(A_CUR, v); chk("R2 step at one period", v, 32'd999);
    wrReg(A_INIT, 32'd0);
    // Divide write in mid-period restarts the prescaler
    wrReg(A_DIV, 32'h3);   // divide by 16
    wrReg(A_INIT, 32'd1000);
    waitCyc(10);
    wrReg(A_DIV, 32'h3);
    waitCyc(15);
    rdReg(A_CUR, v); chk("R2 divide write restarts period", v, 32'd1000);
    rdReg(A_CUR, v); chk("R2 step after restarted period", v, 32'd999);
    wrReg(A_INIT, 32'd0);
  endtask

  task automatic testOneShot();
    logic [31:0] v;
    int base;
    wrReg(A_VT, 32'h0000_0042);
    wrReg(A_DIV, 32'hB);
    wrReg(A_INIT, 32'd20);
    wrReg(A_CUR, 32'd5);      // must be ignored
    rdReg(A_CUR, v); chk("R9 live-count write ignored", v, 32'd19);
    wrReg(A_INIT, 32'd0);
    base = irqCount;
    wrReg(A_INIT, 32'd5);
    waitCyc(20);
    chk("R5 single pulse on expiry", irqCount - base, 32'd1);
    chk("R5 pulse vector", {24'b0, lastVec}, 32'h42);
    rdReg(A_CUR, v); chk("R5 count parks at zero", v, 32'd0);
    waitCyc(10);
    chk("R5 no pulse after expiry", irqCount - base, 32'd1);
    wrReg(A_INIT, 32'd100);
    waitCyc(10);
    rdReg(A_CUR, v); chk("R3 elapsed steps", v, 32'd90);
    wrReg(A_INIT, 32'd0);
    rdReg(A_CUR, v); chk("R7 zero write stops", v, 32'd0);
    waitCyc(5);
    rdReg(A_CUR, v); chk("R7 stays stopped", v, 32'd0);
  endtask

  task automatic testPeriodic();
    logic [31:0] v;
    wrReg(A_VT, 32'h0002_0077);
    wrReg(A_DIV, 32'hB);
    wrReg(A_INIT, 32'd4);
    irqCount = 0;
    waitCyc(22);
    wrReg(A_INIT, 32'd0);
    chk("R6 periodic pulse count", irqCount, 32'd4);
    chk("R6 periodic vector", {24'b0, lastVec}, 32'h77);
    waitCyc(12);
    chk("R7 no pulse after stop", irqCount, 32'd4);
    rdReg(A_CUR, v); chk("R7 live count zero after stop", v, 32'd0);
  endtask

  task automatic testMask();
    logic [31:0] v;
    wrReg(A_VT, 32'h0001_0055);
    wrReg(A_DIV, 32'hB);
    irqCount = 0;
    wrReg(A_INIT, 32'd10);
    waitCyc(4);
    rdReg(A_CUR, v); chk("R4 masked timer still counts", v, 32'd6);
    waitCyc(20);
    rdReg(A_CUR, v); chk("R4 masked timer reaches zero", v, 32'd0);
    chk("R4 masked expiry silent", irqCount, 32'd0);
  endtask

  task automatic testDeadline();
    logic [31:0] v;
    wrReg(A_VT, 32'h0004_0033);
    wrReg(A_DIV, 32'hB);
    irqCount = 0;
    wrReg(A_INIT, 32'd50);
    rdReg(A_CUR, v);  chk("R8 deadline holds zero", v, 32'd0);
    rdReg(A_INIT, v); chk("R10 start count readback", v, 32'd50);
    waitCyc(60);
    rdReg(A_CUR, v);  chk("R8 deadline still zero", v, 32'd0);
    chk("R8 deadline no pulse", irqCount, 32'd0);
    wrReg(A_INIT, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testDivide();
    testFirstStep();
    testOneShot();
    testPeriodic();
    testMask();
    testDeadline();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule